// File: doc/BRIEF.md
# Integer ALU with Condition Codes

This block is the integer execution unit of a load/store RISC core. Each operation reads two source values and produces one 32-bit destination value; it never writes back into its sources. The second operand is taken either from the second register read port or from a 13-bit signed immediate field, which is sign-extended to the full data width. The unit clears, moves, adds and subtracts. Multiply, divide, logic and shift operations are not part of it.

The add and subtract operations each come in a plain form and a flag-setting form. Only the flag-setting form writes the 4-bit condition register, which holds negative, zero, overflow and carry. The result path is purely combinational. The condition register is updated on the rising clock edge when the operation is marked valid.

Top module: `alu_cc_top`

## Requirements
- R1: When `imm_sel_i` is 0 the second operand is `rs2_i`. When it is 1 the second operand is `imm_i` sign-extended to 32 bits. `result_o` follows the inputs combinationally, within the same cycle.
- R2: The immediate covers -4096 to 4095. Bit 12 of `imm_i` is copied into result bits 31..13, so 13'h1000 reads as 32'hFFFFF000 and 13'h0FFF reads as 32'h00000FFF.
- R3: Opcodes 3'b000 and 3'b100 (clear) drive `result_o` to zero whatever the operands are.
- R4: Opcodes 3'b001 and 3'b101 (move) drive `result_o` to the second operand.
- R5: Opcodes 3'b010 (add) and 3'b110 (add, set flags) drive `result_o` to rs1 + op2 modulo 2^32.
- R6: Opcodes 3'b011 (subtract) and 3'b111 (subtract, set flags) drive `result_o` to rs1 - op2 modulo 2^32.
- R7: On a clock edge with `valid_i` high and opcode 3'b110, `flags_o` takes the values of the add. The bits are {N,Z,V,C} = bits [3:0]: N is result bit 31, Z is set when the result is zero, V is set on signed overflow, and C is the carry out of bit 31.
- R8: On a clock edge with `valid_i` high and opcode 3'b111, `flags_o` takes N and Z from the difference. V is set on signed overflow of rs1 - op2. C is set on an unsigned borrow, meaning rs1 < op2 as unsigned numbers.
- R9: `flags_o` does not change on a clock edge when `valid_i` is low, or when the opcode is anything other than 3'b110 or 3'b111.
- R10: While `rst_ni` is low, `flags_o` is held at 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the condition register updates on the rising edge |
| rst_ni | input | 1 | Active-low reset of the condition register |
| valid_i | input | 1 | Marks the current operation as issued; gates the flag update |
| op_i | input | 3 | Opcode: bit 2 selects the flag-setting form, bits 1:0 select clear/move/add/sub |
| rs1_i | input | 32 | First source operand |
| rs2_i | input | 32 | Second source operand when the immediate is not selected |
| imm_sel_i | input | 1 | 1 selects the sign-extended immediate as the second operand |
| imm_i | input | 13 | Signed immediate field |
| result_o | output | 32 | Destination value, combinational |
| flags_o | output | 4 | Condition register {N,Z,V,C} |

## Verification
`result_o` is due in the same cycle as its operands. The bench drives inputs just after the falling edge and samples the result one time unit later, before any rising edge. A flag update is due on the first rising edge after the operation is presented. The bench therefore samples `flags_o` one time unit after that edge and compares it with its own model of the condition register. The model is written only on flag-setting valid operations, so an unwanted update by a plain, invalid or move/clear opcode shows up as a mismatch at the next flag sample.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

   // opcode: bit 2 = set-flags form, bits 1:0 = function
   typedef enum logic [1:0] {
      FN_CLR = 2'b00,
      FN_MOV = 2'b01,
      FN_ADD = 2'b10,
      FN_SUB = 2'b11
   } alu_fn_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } cc_flags_t;

   localparam int unsigned OP_W     = 3;
   localparam int unsigned CC_W     = 4;
   localparam int unsigned SETCC_BIT = 2;

endpackage

// File: rtl/alu_cc_opsel.sv
module alu_cc_opsel #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] reg_i,
   input  logic              imm_sel_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] op2_o
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   initial begin
      if (IMM_W < 2 || IMM_W > DATA_W)
         $error("alu_cc_opsel: IMM_W must be in 2..DATA_W");
   end

   logic [DATA_W-1:0] imm_ext;

   generate
      if (EXT_W == 0) begin : g_full_imm
         assign imm_ext = imm_i;
      end else begin : g_sext_imm
         assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      end
   endgenerate

   assign op2_o = imm_sel_i ? imm_ext : reg_i;

   // R2: upper bits replicate the immediate sign
   p_sext_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      imm_sel_i |-> ((op2_o[DATA_W-1:IMM_W-1] == '0) ||
                     (op2_o[DATA_W-1:IMM_W-1] == '1)) &&
                    (op2_o[IMM_W-1] == imm_i[IMM_W-1]));

   // R1: register operand passes untouched
   p_regpass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !imm_sel_i |-> (op2_o == reg_i));

endmodule

// File: rtl/alu_cc_addsub.sv
module alu_cc_addsub
   import alu_cc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output cc_flags_t         cc_o
);

   localparam int unsigned MSB = DATA_W - 1;

   initial begin
      if (DATA_W < 2)
         $error("alu_cc_addsub: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;
   logic              carry_out;

   // subtract as a + ~b + 1
   assign b_eff     = sub_i ? ~b_i : b_i;
   assign wide      = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
   assign sum_o     = wide[DATA_W-1:0];
   assign carry_out = wide[DATA_W];

   always_comb begin
      cc_o.n = sum_o[MSB];
      cc_o.z = (sum_o == '0);
      cc_o.v = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
      // borrow is the inverted carry when subtracting
      cc_o.c = sub_i ? ~carry_out : carry_out;
   end

   // R8: borrow flag equals unsigned less-than
   p_borrow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sub_i |-> (cc_o.c == (a_i < b_i)));

   // R7: carry flag on add equals unsigned wrap
   p_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sub_i |-> (cc_o.c == (sum_o < a_i)));

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
   import alu_cc_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      upd_i,
   input  cc_flags_t cc_i,
   output cc_flags_t cc_q_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cc_q_o <= '0;
      else if (upd_i)
         cc_q_o <= cc_i;
   end

   // R9: no update request, no change
   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_i |=> $stable(cc_q_o));

   // R7: update request loads the offered flags
   p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_i |=> (cc_q_o == $past(cc_i)));

endmodule

// File: rtl/alu_cc_top.sv
module alu_cc_top
   import alu_cc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IMM_W  = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              valid_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] rs1_i,
   input  logic [DATA_W-1:0] rs2_i,
   input  logic              imm_sel_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flags_o
);

   initial begin
      if (DATA_W < IMM_W)
         $error("alu_cc_top: DATA_W must not be smaller than IMM_W");
   end

   alu_fn_e           fn;
   logic              setcc;
   logic [DATA_W-1:0] op2_w;
   logic [DATA_W-1:0] sum_w;
   cc_flags_t         cc_next;
   cc_flags_t         cc_q;
   logic              upd;

   assign fn    = alu_fn_e'(op_i[1:0]);
   assign setcc = op_i[SETCC_BIT];

   alu_cc_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .reg_i     (rs2_i),
      .imm_sel_i (imm_sel_i),
      .imm_i     (imm_i),
      .op2_o     (op2_w)
   );

   alu_cc_addsub #(.DATA_W(DATA_W)) u_addsub (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (rs1_i),
      .b_i    (op2_w),
      .sub_i  (fn == FN_SUB),
      .sum_o  (sum_w),
      .cc_o   (cc_next)
   );

   // only add/sub set-flags forms touch the condition register
   assign upd = valid_i && setcc && ((fn == FN_ADD) || (fn == FN_SUB));

   alu_cc_flagreg u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (upd),
      .cc_i   (cc_next),
      .cc_q_o (cc_q)
   );

   always_comb begin
      unique case (fn)
         FN_CLR:  result_o = '0;
         FN_MOV:  result_o = op2_w;
         default: result_o = sum_w;
      endcase
   end

   assign flags_o = cc_q;

   // R3: clear yields zero
   p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[1:0] == 2'b00) |-> (result_o == '0));

   // R4: move yields the selected second operand
   p_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[1:0] == 2'b01) |-> (result_o == op2_w));

   // R7: zero flag after a flag-setting op reflects the result
   p_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd |=> (flags_o[2] == ($past(result_o) == '0)));

   // R9: clear/move never change flags
   p_nochg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i[1] == 1'b0) |=> $stable(flags_o));

endmodule

// File: tb/alu_cc_top_tb_top.sv
module alu_cc_top_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [2:0]  op = 3'b000;
   logic [31:0] rs1 = '0;
   logic [31:0] rs2 = '0;
   logic        isel = 1'b0;
   logic [12:0] imm = '0;
   logic [31:0] result;
   logic [3:0]  flags;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [3:0] model_cc = 4'b0000;

   always #(CLK_P/2) clk = ~clk;

   alu_cc_top dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .valid_i   (valid),
      .op_i      (op),
      .rs1_i     (rs1),
      .rs2_i     (rs2),
      .imm_sel_i (isel),
      .imm_i     (imm),
      .result_o  (result),
      .flags_o   (flags)
   );

   function automatic logic [31:0] f_op2(logic s, logic [31:0] r, logic [12:0] i);
      longint v;
      v = i[12] ? longint'(i) - 8192 : longint'(i);
      return s ? v[31:0] : r;
   endfunction

   function automatic logic [31:0] f_res(logic [2:0] o, logic [31:0] a, logic [31:0] b);
      case (o[1:0])
         2'b00:   return 32'h0;
         2'b01:   return b;
         2'b10:   return a + b;
         default: return a - b;
      endcase
   endfunction

   function automatic logic [3:0] f_cc(logic sub, logic [31:0] a, logic [31:0] b);
      longint sa, sb, sr;
      logic [31:0] r;
      logic n, z, v, c;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sr = sub ? sa - sb : sa + sb;
      r  = sub ? a - b : a + b;
      n  = r[31];
      z  = (r == 32'h0);
      v  = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
      c  = sub ? (a < b) : ((longint'(a) + longint'(b)) > 64'd4294967295);
      return {n, z, v, c};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(string req, logic v, logic [2:0] o, logic [31:0] a,
                         logic [31:0] r2, logic s, logic [12:0] i);
      logic [31:0] b;
      @(negedge clk);
      valid = v; op = o; rs1 = a; rs2 = r2; isel = s; imm = i;
      b = f_op2(s, r2, i);
      #1;
      check(req, result, f_res(o, a, b));
      if (v && o[2] && o[1])
         model_cc = f_cc(o[0], a, b);
      @(posedge clk);
      #1;
      check((v && o[2] && o[1]) ? (o[0] ? "R8" : "R7") : "R9",
            {28'h0, flags}, {28'h0, model_cc});
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      // R10: flags cleared in reset
      repeat (3) @(posedge clk);
      #1;
      check("R10", {28'h0, flags}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: immediate extremes
      run_op("R2", 1, 3'b001, 32'h0, 32'h0, 1, 13'h1000);
      run_op("R2", 1, 3'b001, 32'h0, 32'h0, 1, 13'h0FFF);
      run_op("R1", 1, 3'b001, 32'h0, 32'hDEADBEEF, 0, 13'h1000);
      // R3: clear ignores operands
      run_op("R3", 1, 3'b100, 32'hFFFFFFFF, 32'h12345678, 0, 13'h0);
      // R7: add overflow, carry, zero
      run_op("R7", 1, 3'b110, 32'h7FFFFFFF, 32'h1, 0, 13'h0);
      run_op("R7", 1, 3'b110, 32'hFFFFFFFF, 32'h1, 0, 13'h0);
      run_op("R7", 1, 3'b110, 32'h5, 32'h0, 1, 13'h1FFB);
      // R9: plain add, invalid set-flags, move-with-bit2 keep flags
      run_op("R5", 1, 3'b010, 32'h0, 32'h0, 0, 13'h0);
      run_op("R9", 0, 3'b111, 32'h0, 32'h1, 0, 13'h0);
      run_op("R4", 1, 3'b101, 32'h0, 32'h0, 0, 13'h0);
      // R8: borrow, equal, signed overflow
      run_op("R8", 1, 3'b111, 32'h0, 32'h1, 0, 13'h0);
      run_op("R8", 1, 3'b111, 32'h1234, 32'h1234, 0, 13'h0);
      run_op("R8", 1, 3'b111, 32'h80000000, 32'h1, 0, 13'h0);
      run_op("R6", 1, 3'b011, 32'h10, 32'h0, 1, 13'h1000);

      for (int k = 0; k < 400; k++) begin
         logic [2:0]  o;
         logic [31:0] a, b;
         a = $urandom();
         b = $urandom();
         if (k % 4 == 0) a = {a[31], 31'h7FFFFFFF} ^ {32{a[0]}};
         o = 3'($urandom_range(7));
         run_op(o[1] ? (o[0] ? "R6" : "R5") : (o[0] ? "R4" : "R3"),
                ($urandom_range(3) != 0), o, a, b, $urandom_range(1), 13'($urandom()));
      end

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule